// File: doc/BRIEF.md
# Strided Vector Load Unit over Interleaved Banks

This block fills one vector register from a word-addressed memory that is split into several independent banks. A start strobe supplies a base word address, a stride and an element count. The unit then walks the addresses base, base+stride, base+2·stride and so on, modulo the address width. For each element it sends one request per cycle to the bank that owns that word. Each bank stays occupied for a fixed number of cycles after it accepts a request. When the next element falls on a bank that is still occupied, issue waits. Unit strides therefore run at one word per clock after the initial latency. Strides that keep hitting a few banks slow the unit down.

Read data returns from the banks a fixed number of cycles after each request. Because every request has the same latency and requests leave in element order, responses arrive in element order. The unit writes each response into the vector register at the index of its element. A one-cycle completion pulse follows the last write.

The element count is clamped to the register capacity. A count of zero completes at once. The request channel has no ready signal, because the unit itself tracks which banks are free and never sends a request to an occupied bank. The response channel and the register write port likewise carry a valid strobe only: the memory cannot be held off, and the register file always accepts a write.

Top module: `strided_vload`

## Requirements
- R1: The element count taken at start is `vlen_i` when it is at most MAX_VL (64), and MAX_VL otherwise. Exactly that many register writes occur, with indices below MAX_VL.
- R2: Element i uses word address (base + i·stride) mod 2^ADDR_W, so a stride of all ones walks downward. The bank is the low log2(NBANK) bits of that address and the row is the remaining upper bits (`req_bank_o`, `req_row_o`).
- R3: A bank that received a request in cycle t gets no other request before cycle t+BANK_LAT (6). An element whose bank is occupied waits until it is free.
- R4: At most one request leaves per cycle, and an element issues in the first cycle in which its bank is free. The first request comes in the cycle after the start strobe is sampled. For unit stride and n elements, `done_o` is high n+8 cycles after the strobe cycle.
- R5: A response seen with `rsp_valid_i` in cycle t produces `vreg_we_o` in cycle t+1. That write carries the response data, and its index is 0, 1, 2, … in order.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last register write. No request is present while it is high, and the unit is idle again in that cycle.
- R7: A start with element count zero sends no request, makes no write, and raises `done_o` in the cycle after the strobe.
- R8: A start strobe is taken only while the unit is idle. A strobe during a transfer does not change that transfer's addresses, count or timing.
- R9: While reset is held, and directly after it, `req_valid_o`, `vreg_we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Word distance between elements (wraps modulo 2^ADDR_W) |
| vlen_i | input | VLIN_W | Requested element count |
| req_valid_o | output | 1 | Bank request strobe |
| req_bank_o | output | log2(NBANK) | Bank selected for the request |
| req_row_o | output | ADDR_W-log2(NBANK) | Word address inside the bank |
| rsp_valid_i | input | 1 | Read data strobe, BANK_LAT cycles after the request |
| rsp_data_i | input | DATA_W | Read data |
| vreg_we_o | output | 1 | Vector register write enable |
| vreg_idx_o | output | log2(MAX_VL) | Element index being written |
| vreg_data_o | output | DATA_W | Element data being written |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: eight banks, a six-cycle bank occupancy, 64 elements, 16-bit word addresses and 32-bit data. With eight banks and a six-cycle occupancy, each stride class behaves differently. Odd strides never stall. A stride of 2 issues four requests out of every six cycles. A stride of 4 alternates between two banks. A stride of 8 serialises every request on one bank.

Requested counts above 64 reach the clamp, and a downward stride starting near zero reaches address wrap-around. Cycle-exact completion times for each case, together with a bank-occupancy model held in the bench, separate a correct stall decision from one that is early or late.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } vld_state_e;
endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  localparam int ROW_W = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              adv_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] stride_q;

  // running address: one adder, no multiplier per element
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      cur_q    <= base_i;
      stride_q <= stride_i;
    end else if (adv_i) begin
      cur_q    <= cur_q + stride_q;
    end
  end

  assign bank_o = cur_q[BANK_W-1:0];
  assign row_o  = cur_q[ADDR_W-1:BANK_W];
endmodule

// File: rtl/vld_bank_track.sv
module vld_bank_track #(
  parameter int NBANK    = 8,
  parameter int BANK_LAT = 6,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int CNT_W   = $clog2(BANK_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [BANK_W-1:0] issue_bank_i,
  output logic [NBANK-1:0]  free_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0] occ_q;

    // counts the remaining occupied cycles after the issue cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q <= '0;
      end else if (issue_i && issue_bank_i == BANK_W'(b)) begin
        occ_q <= CNT_W'(BANK_LAT - 1);
      end else if (occ_q != '0) begin
        occ_q <= occ_q - CNT_W'(1);
      end
    end

    assign free_o[b] = (occ_q == '0);
  end
endmodule

// File: rtl/vld_writeback.sv
module vld_writeback #(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic [VL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      we_o   <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
      last_o <= 1'b0;
    end else begin
      we_o   <= rsp_valid_i;
      last_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (rsp_valid_i) begin
        idx_o  <= cnt_q[IDX_W-1:0];
        data_o <= rsp_data_i;
        cnt_q  <= cnt_q + VL_W'(1);
        last_o <= (cnt_q == vl_i - VL_W'(1));
      end
    end
  end
endmodule

// File: rtl/strided_vload.sv
module strided_vload #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NBANK    = 8,
  parameter int BANK_LAT = 6,
  parameter int MAX_VL   = 64,
  parameter int VLIN_W   = 8,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int ROW_W   = ADDR_W - BANK_W,
  localparam int IDX_W   = $clog2(MAX_VL),
  localparam int VL_W    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VLIN_W-1:0] vlen_i,
  output logic              req_valid_o,
  output logic [BANK_W-1:0] req_bank_o,
  output logic [ROW_W-1:0]  req_row_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              vreg_we_o,
  output logic [IDX_W-1:0]  vreg_idx_o,
  output logic [DATA_W-1:0] vreg_data_o,
  output logic              done_o
);
  import vld_pkg::*;

  vld_state_e      state_q;
  logic [VL_W-1:0] vl_q;
  logic [VL_W-1:0] iss_cnt_q;
  logic [VL_W-1:0] vl_clamp;
  logic [NBANK-1:0] bank_free;
  logic            accept;
  logic            issue;
  logic            last_issue;
  logic            wb_last;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign vl_clamp = (vlen_i > VLIN_W'(MAX_VL)) ? VL_W'(MAX_VL) : VL_W'(vlen_i);

  vld_addr_gen #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .base_i   (base_i),
    .stride_i (stride_i),
    .adv_i    (issue),
    .bank_o   (req_bank_o),
    .row_o    (req_row_o)
  );

  vld_bank_track #(.NBANK(NBANK), .BANK_LAT(BANK_LAT)) u_banks (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue),
    .issue_bank_i (req_bank_o),
    .free_o       (bank_free)
  );

  vld_writeback #(.DATA_W(DATA_W), .MAX_VL(MAX_VL)) u_wb (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (accept),
    .vl_i        (vl_q),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .we_o        (vreg_we_o),
    .idx_o       (vreg_idx_o),
    .data_o      (vreg_data_o),
    .last_o      (wb_last)
  );

  assign issue       = (state_q == ST_RUN) && bank_free[req_bank_o];
  assign last_issue  = issue && (iss_cnt_q == vl_q - VL_W'(1));
  assign req_valid_o = issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      vl_q      <= '0;
      iss_cnt_q <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vl_q      <= vl_clamp;
            iss_cnt_q <= '0;
            if (vl_clamp == '0) done_o  <= 1'b1;
            else                state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (issue) iss_cnt_q <= iss_cnt_q + VL_W'(1);
          if (last_issue) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (wb_last) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vld_checker.sv
module vld_checker #(
  parameter int NBANK    = 8,
  parameter int BANK_LAT = 6,
  parameter int MAX_VL   = 64,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int IDX_W   = $clog2(MAX_VL),
  localparam int CW      = $clog2(BANK_LAT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic              rsp_valid,
  input logic              vreg_we,
  input logic [IDX_W-1:0]  vreg_idx,
  input logic              done
);
  logic [CW-1:0] hold_q [NBANK];

  // independent occupancy window per bank, kept with counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) hold_q[b] <= '0;
    end else begin
      a_r3_no_busy_bank: assert (!(req_valid && hold_q[req_bank] != '0))
        else $error("request to occupied bank %0d", req_bank);
      for (int b = 0; b < NBANK; b++) begin
        if (req_valid && req_bank == BANK_W'(b)) hold_q[b] <= CW'(BANK_LAT - 1);
        else if (hold_q[b] != '0)               hold_q[b] <= hold_q[b] - CW'(1);
      end
    end
  end

  a_r5_write_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> vreg_we);

  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_we && $past(vreg_we)) |-> (vreg_idx == IDX_W'($past(vreg_idx) + 1'b1)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

bind strided_vload vld_checker #(
  .NBANK(NBANK), .BANK_LAT(BANK_LAT), .MAX_VL(MAX_VL)
) u_vld_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid_o),
  .req_bank  (req_bank_o),
  .rsp_valid (rsp_valid_i),
  .vreg_we   (vreg_we_o),
  .vreg_idx  (vreg_idx_o),
  .done      (done_o)
);

// File: tb/strided_vload_bench.sv
module strided_vload_bench;
  localparam int LAT = 6;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] stride;
    logic [7:0]  vl;
    logic [15:0] cyc;
  } vec_t;

  // base, stride, requested count, cycles from strobe to done
  localparam vec_t VECS [8] = '{
    '{16'd0,    16'd1,    8'd64,  16'd72},  // unit stride, full length
    '{16'd5,    16'd3,    8'd20,  16'd28},  // odd stride, no stall
    '{16'd16,   16'd8,    8'd5,   16'd33},  // same bank every element
    '{16'd2,    16'd2,    8'd10,  16'd22},  // four banks in rotation
    '{16'd3,    16'hFFFF, 8'd12,  16'd20},  // downward with wrap
    '{16'd7,    16'd4,    8'd6,   16'd22},  // two banks alternate
    '{16'd0,    16'd1,    8'd100, 16'd72},  // count above capacity
    '{16'd9,    16'd1,    8'd0,   16'd1}    // empty vector
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base = '0;
  logic [15:0] stride = '0;
  logic [7:0]  vlen = '0;
  logic        req_valid;
  logic [2:0]  req_bank;
  logic [12:0] req_row;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        vreg_we;
  logic [5:0]  vreg_idx;
  logic [31:0] vreg_data;
  logic        done;

  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;
  int n_req = 0, n_wr = 0;
  logic [15:0] ex_base = '0, ex_stride = '0;
  int cycles = 0;
  logic wd_fired = 1'b0;

  always #10 clk = ~clk;

  strided_vload u_strided_vload (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base),
    .stride_i(stride), .vlen_i(vlen),
    .req_valid_o(req_valid), .req_bank_o(req_bank), .req_row_o(req_row),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .vreg_we_o(vreg_we), .vreg_idx_o(vreg_idx), .vreg_data_o(vreg_data),
    .done_o(done)
  );

  function automatic logic [31:0] word_at(logic [15:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

  // bank model: fixed latency pipeline
  logic        p_v [LAT];
  logic [15:0] p_a [LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) p_v[i] <= 1'b0;
    end else begin
      p_v[0] <= req_valid;
      p_a[0] <= {req_row, req_bank};
      for (int i = 1; i < LAT; i++) begin
        p_v[i] <= p_v[i-1];
        p_a[i] <= p_a[i-1];
      end
    end
  end
  assign rsp_valid = p_v[LAT-1];
  assign rsp_data  = word_at(p_a[LAT-1]);

  task automatic mfail(string req, string what, int act, int exp);
    m_errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // port monitor sampled away from the active edge
  int   busy [8];
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 8; b++) busy[b] = 0;
      prev_done = 1'b0;
    end else begin
      for (int b = 0; b < 8; b++) if (busy[b] > 0) busy[b]--;
      if (req_valid) begin
        logic [15:0] ea;
        ea = ex_base + 16'(n_req) * ex_stride;
        m_checks++;
        if ({req_row, req_bank} != ea) mfail("R2", "request address", {req_row, req_bank}, ea);
        m_checks++;
        if (busy[req_bank] != 0) mfail("R3", "request to occupied bank", busy[req_bank], 0);
        busy[req_bank] = LAT;
        n_req++;
      end
      if (vreg_we) begin
        m_checks++;
        if (vreg_idx != 6'(n_wr)) mfail("R5", "write index", vreg_idx, n_wr);
        m_checks++;
        if (vreg_data != word_at(ex_base + 16'(n_wr) * ex_stride))
          mfail("R5", "write data", vreg_data, word_at(ex_base + 16'(n_wr) * ex_stride));
        n_wr++;
      end
      m_checks++;
      if (done && prev_done) mfail("R6", "done pulse width", 2, 1);
      prev_done = done;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors",
             checks + m_checks, errors + m_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !wd_fired) begin
      wd_fired = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // start a transfer at a falling edge and count edges until done
  task automatic launch(logic [15:0] b, logic [15:0] s, logic [7:0] v, output int d);
    ex_base = b; ex_stride = s; n_req = 0; n_wr = 0;
    base = b; stride = s; vlen = v; start = 1'b1;
    d = 0;
    @(posedge clk); d++;
    @(negedge clk); start = 1'b0;
    while (!done && d < 2000) begin
      @(posedge clk); d++;
      @(negedge clk);
    end
  endtask

  initial begin
    int d;
    int nexp;
    repeat (3) @(negedge clk);
    check("R9", "req_valid in reset", req_valid, 0);
    check("R9", "vreg_we in reset", vreg_we, 0);
    check("R9", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "req_valid after reset", req_valid, 0);
    check("R9", "done after reset", done, 0);

    for (int k = 0; k < 8; k++) begin
      launch(VECS[k].base, VECS[k].stride, VECS[k].vl, d);
      nexp = (VECS[k].vl > 64) ? 64 : int'(VECS[k].vl);
      // R4 timing and stall placement; R7 for the empty case
      check(VECS[k].vl == 0 ? "R7" : "R4", "cycles to done", d, int'(VECS[k].cyc));
      check("R1", "register writes", n_wr, nexp);
      check(VECS[k].vl == 0 ? "R7" : "R2", "requests sent", n_req, nexp);
      @(negedge clk);
      check("R6", "done low after pulse", done, 0);
      repeat (2) @(negedge clk);
    end

    // R8: strobe during a transfer is ignored
    ex_base = 16'd0; ex_stride = 16'd8; n_req = 0; n_wr = 0;
    base = 16'd0; stride = 16'd8; vlen = 8'd4; start = 1'b1;
    d = 0;
    @(posedge clk); d++;
    @(negedge clk); start = 1'b0;
    repeat (3) begin @(posedge clk); d++; @(negedge clk); end
    base = 16'd1; stride = 16'd1; vlen = 8'd3; start = 1'b1;
    @(posedge clk); d++;
    @(negedge clk); start = 1'b0;
    while (!done && d < 2000) begin
      @(posedge clk); d++;
      @(negedge clk);
    end
    check("R8", "cycles with ignored strobe", d, 27);
    check("R8", "writes with ignored strobe", n_wr, 4);
    check("R8", "requests with ignored strobe", n_req, 4);
    repeat (12) @(negedge clk);
    check("R8", "no late requests", n_req, 4);
    check("R6", "idle after done", req_valid, 0);

    finish_run();
  end
endmodule